// File: doc/BRIEF.md
# Load/Store Data Alignment Unit

This block sits between a 32-bit integer pipeline and a byte-addressed memory port that is 32 bits wide. For every request it adds a sign-extended 16-bit offset to a base register value to form the effective address. For stores it copies the byte, halfword or word onto every lane it could land on and raises only the byte enables of the lanes that are written. For loads it remembers the size, signedness and lane of the request. One cycle later, when the memory returns the word, it picks out the addressed byte or halfword and extends it to 32 bits.

Eight operations are decoded from a 3-bit code on `op_i`: 0 signed byte load, 1 signed halfword load, 2 word load, 3 unsigned byte load, 4 unsigned halfword load, 5 byte store, 6 halfword store, 7 word store. Lanes are little-endian. Effective-address bits [1:0] pick the byte lane and bit [1] picks the halfword lane. A halfword access at an odd address, or a word access that is not on a 4-byte boundary, is reported as an address error and never reaches memory.

Top module: `lsu_align_unit`

## Requirements
- R1: `mem_addr_o` equals `base_i` plus `offset_i` sign-extended to 32 bits, modulo 2^32, in the same cycle as the request.
- R2: A byte store (op 5) drives the low 8 bits of `store_data_i` on all four lanes of `mem_wdata_o`. `mem_be_o` has only bit `ea[1:0]` set.
- R3: A halfword store (op 6) drives the low 16 bits of `store_data_i` on both halves of `mem_wdata_o`. `mem_be_o` is 4'b0011 when `ea[1]` is 0 and 4'b1100 when it is 1.
- R4: A word store (op 7) drives all 32 bits of `store_data_i` with `mem_be_o` = 4'b1111.
- R5: A signed byte load (op 0) returns on `load_data_o` the byte in lane `ea[1:0]` of `mem_rdata_i`, sign-extended. It is valid in the cycle after the request.
- R6: An unsigned byte load (op 3) returns the addressed byte zero-extended, with the same timing as R5.
- R7: A signed halfword load (op 1) returns halfword `ea[1]` of `mem_rdata_i`, sign-extended.
- R8: An unsigned halfword load (op 4) returns halfword `ea[1]` of `mem_rdata_i`, zero-extended.
- R9: A word load (op 2) returns `mem_rdata_i` unchanged.
- R10: A request is misaligned when it is a halfword access with `ea[0]`=1, or a word access with `ea[1:0]`≠0. A misaligned request raises `addr_err_o` and holds `mem_req_o`, `mem_we_o` and `mem_be_o` at zero. A misaligned load produces no `load_valid_o` in the next cycle. Byte accesses are never misaligned.
- R11: For an aligned request, `mem_req_o` is 1. `mem_we_o` is 1 only for ops 5 to 7. `load_valid_o` rises in the next cycle only for ops 0 to 4.
- R12: While `rst_ni` is low, and after reset until the first load, `load_valid_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | A request is present this cycle |
| op_i | input | 3 | Operation code (0 to 7, see above) |
| base_i | input | 32 | Base register value |
| offset_i | input | 16 | Signed address offset |
| store_data_i | input | 32 | Source register for stores |
| mem_addr_o | output | 32 | Effective byte address |
| mem_req_o | output | 1 | Aligned access issued to memory |
| mem_we_o | output | 1 | Write strobe |
| mem_be_o | output | 4 | Byte-lane enables |
| mem_wdata_o | output | 32 | Lane-replicated write data |
| addr_err_o | output | 1 | Misaligned request |
| mem_rdata_i | input | 32 | Word returned by memory, one cycle after a load request |
| load_valid_o | output | 1 | `load_data_o` is valid |
| load_data_o | output | 32 | Extended load result |

## Verification
The address, write data, byte enables, request strobe and error flag depend only on the current inputs. The bench drives a request on the falling edge and checks those outputs 1 ns later, in the same cycle. A load result is due one cycle after its request. The request is taken at the rising edge, so the bench clears the request on the following falling edge, presents `mem_rdata_i` there, and checks `load_valid_o` and `load_data_o` 1 ns later. The same sampling point is used to confirm that no `load_valid_o` follows a misaligned or store request.

// File: rtl/lsu_align_pkg.sv
package lsu_align_pkg;

   typedef enum logic [2:0] {
      OP_LD_B_S = 3'd0,
      OP_LD_H_S = 3'd1,
      OP_LD_W   = 3'd2,
      OP_LD_B_U = 3'd3,
      OP_LD_H_U = 3'd4,
      OP_ST_B   = 3'd5,
      OP_ST_H   = 3'd6,
      OP_ST_W   = 3'd7
   } lsu_op_e;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2
   } lsu_size_e;

   function automatic lsu_size_e op_size(lsu_op_e op);
      case (op)
         OP_LD_B_S, OP_LD_B_U, OP_ST_B: op_size = SZ_BYTE;
         OP_LD_H_S, OP_LD_H_U, OP_ST_H: op_size = SZ_HALF;
         default:                       op_size = SZ_WORD;
      endcase
   endfunction

   function automatic logic op_is_store(lsu_op_e op);
      op_is_store = (op == OP_ST_B) || (op == OP_ST_H) || (op == OP_ST_W);
   endfunction

   function automatic logic op_is_unsigned(lsu_op_e op);
      op_is_unsigned = (op == OP_LD_B_U) || (op == OP_LD_H_U);
   endfunction

endpackage

// File: rtl/lsu_addr_gen.sv
module lsu_addr_gen
   import lsu_align_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int OFF_W  = 16
) (
   input  logic [ADDR_W-1:0] base_i,
   input  logic [OFF_W-1:0]  offset_i,
   input  lsu_size_e         size_i,
   output logic [ADDR_W-1:0] ea_o,
   output logic              misaligned_o
);

   localparam int EXT_W = ADDR_W - OFF_W;

   generate
      if (OFF_W > ADDR_W || OFF_W < 2) begin : g_bad_width
         $error("lsu_addr_gen: OFF_W must lie in [2, ADDR_W]");
      end
   endgenerate

   logic [ADDR_W-1:0] off_sext;

   generate
      if (EXT_W > 0) begin : g_sext
         assign off_sext = {{EXT_W{offset_i[OFF_W-1]}}, offset_i};
      end else begin : g_nosext
         assign off_sext = offset_i;
      end
   endgenerate

   assign ea_o = base_i + off_sext;

   always_comb begin
      case (size_i)
         SZ_HALF: misaligned_o = ea_o[0];
         SZ_WORD: misaligned_o = |ea_o[1:0];
         default: misaligned_o = 1'b0;
      endcase
   end

endmodule

// File: rtl/lsu_store_steer.sv
module lsu_store_steer
   import lsu_align_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              en_i,
   input  lsu_size_e         size_i,
   input  logic [1:0]        lane_i,
   input  logic [DATA_W-1:0] data_i,
   output logic [DATA_W-1:0] wdata_o,
   output logic [DATA_W/8-1:0] be_o
);

   localparam int LANES = DATA_W / 8;

   generate
      if (DATA_W != 32) begin : g_bad_width
         $error("lsu_store_steer: DATA_W must be 32");
      end
   endgenerate

   generate
      for (genvar g = 0; g < LANES; g++) begin : g_lane
         localparam int HALF_IDX = g / 2;
         localparam int IN_HALF  = g % 2;
         always_comb begin
            case (size_i)
               SZ_BYTE: begin
                  wdata_o[8*g +: 8] = data_i[7:0];
                  be_o[g]           = en_i && (lane_i == 2'(g));
               end
               SZ_HALF: begin
                  wdata_o[8*g +: 8] = data_i[8*IN_HALF +: 8];
                  be_o[g]           = en_i && (lane_i[1] == 1'(HALF_IDX));
               end
               default: begin
                  wdata_o[8*g +: 8] = data_i[8*g +: 8];
                  be_o[g]           = en_i;
               end
            endcase
         end
      end
   endgenerate

endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract
   import lsu_align_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              take_i,
   input  lsu_size_e         size_i,
   input  logic              unsigned_i,
   input  logic [1:0]        lane_i,
   input  logic [DATA_W-1:0] rdata_i,
   output logic              valid_o,
   output logic [DATA_W-1:0] data_o
);

   generate
      if (DATA_W != 32) begin : g_bad_width
         $error("lsu_load_extract: DATA_W must be 32");
      end
   endgenerate

   lsu_size_e  q_size;
   logic       q_uns;
   logic [1:0] q_lane;
   logic [7:0]  sel_byte;
   logic [15:0] sel_half;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         valid_o <= 1'b0;
         q_size  <= SZ_WORD;
         q_uns   <= 1'b0;
         q_lane  <= 2'd0;
      end else begin
         valid_o <= take_i;
         if (take_i) begin
            q_size <= size_i;
            q_uns  <= unsigned_i;
            q_lane <= lane_i;
         end
      end
   end

   always_comb begin
      case (q_lane)
         2'd0:    sel_byte = rdata_i[7:0];
         2'd1:    sel_byte = rdata_i[15:8];
         2'd2:    sel_byte = rdata_i[23:16];
         default: sel_byte = rdata_i[31:24];
      endcase
      sel_half = q_lane[1] ? rdata_i[31:16] : rdata_i[15:0];
      case (q_size)
         SZ_BYTE: data_o = {{24{sel_byte[7] & ~q_uns}}, sel_byte};
         SZ_HALF: data_o = {{16{sel_half[15] & ~q_uns}}, sel_half};
         default: data_o = rdata_i;
      endcase
   end

   AST_UNS_BYTE_TOP_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(take_i && unsigned_i && size_i == SZ_BYTE) |-> data_o[31:8] == 24'd0); // R6
   AST_UNS_HALF_TOP_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(take_i && unsigned_i && size_i == SZ_HALF) |-> data_o[31:16] == 16'd0); // R8

endmodule

// File: rtl/lsu_align_unit.sv
module lsu_align_unit
   import lsu_align_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter int OFF_W  = 16
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              req_valid_i,
   input  logic [2:0]        op_i,
   input  logic [ADDR_W-1:0] base_i,
   input  logic [OFF_W-1:0]  offset_i,
   input  logic [DATA_W-1:0] store_data_i,
   output logic [ADDR_W-1:0] mem_addr_o,
   output logic              mem_req_o,
   output logic              mem_we_o,
   output logic [DATA_W/8-1:0] mem_be_o,
   output logic [DATA_W-1:0] mem_wdata_o,
   output logic              addr_err_o,
   input  logic [DATA_W-1:0] mem_rdata_i,
   output logic              load_valid_o,
   output logic [DATA_W-1:0] load_data_o
);

   localparam int LANES = DATA_W / 8;

   generate
      if (LANES != 4) begin : g_bad_lanes
         $error("lsu_align_unit: exactly four byte lanes supported");
      end
   endgenerate

   lsu_op_e   op;
   lsu_size_e size;
   logic      is_store;
   logic      misaligned;
   logic      issue;

   assign op       = lsu_op_e'(op_i);
   assign size     = op_size(op);
   assign is_store = op_is_store(op);

   lsu_addr_gen #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) addr_i (
      .base_i       (base_i),
      .offset_i     (offset_i),
      .size_i       (size),
      .ea_o         (mem_addr_o),
      .misaligned_o (misaligned)
   );

   assign addr_err_o = req_valid_i && misaligned;
   assign issue      = req_valid_i && !misaligned;
   assign mem_req_o  = issue;
   assign mem_we_o   = issue && is_store;

   lsu_store_steer #(.DATA_W(DATA_W)) steer_i (
      .en_i    (issue),
      .size_i  (size),
      .lane_i  (mem_addr_o[1:0]),
      .data_i  (store_data_i),
      .wdata_o (mem_wdata_o),
      .be_o    (mem_be_o)
   );

   lsu_load_extract #(.DATA_W(DATA_W)) load_i (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .take_i     (issue && !is_store),
      .size_i     (size),
      .unsigned_i (op_is_unsigned(op)),
      .lane_i     (mem_addr_o[1:0]),
      .rdata_i    (mem_rdata_i),
      .valid_o    (load_valid_o),
      .data_o     (load_data_o)
   );

   AST_ERR_BLOCKS_MEM: assert property (@(posedge clk_i) disable iff (!rst_ni)
      addr_err_o |-> (!mem_req_o && !mem_we_o && mem_be_o == '0)); // R10
   AST_ERR_NO_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      addr_err_o |=> !load_valid_o); // R10
   AST_BE_SHAPE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mem_req_o |-> ($countones(mem_be_o) == 1 || mem_be_o == 4'b0011 ||
                     mem_be_o == 4'b1100 || mem_be_o == 4'b1111)); // R2
   AST_BYTE_ONE_LANE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mem_we_o && op == OP_ST_B) |-> $onehot0(mem_be_o) && mem_be_o != '0); // R2
   AST_LOAD_NEXT_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mem_req_o && !mem_we_o) |=> load_valid_o); // R11
   AST_STORE_NO_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!mem_req_o || mem_we_o) |=> !load_valid_o); // R11

endmodule

// File: tb/lsu_align_unit_tb.sv
module lsu_align_unit_tb_top;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [2:0]  op = 3'd0;
   logic [31:0] base = '0;
   logic [15:0] offset = '0;
   logic [31:0] sdata = '0;
   logic [31:0] rdata = '0;
   logic [31:0] mem_addr;
   logic        mem_req;
   logic        mem_we;
   logic [3:0]  mem_be;
   logic [31:0] mem_wdata;
   logic        addr_err;
   logic        load_valid;
   logic [31:0] load_data;

   int checks = 0;
   int failures = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   lsu_align_unit dut_i (
      .clk_i        (clk),
      .rst_ni       (rst_n),
      .req_valid_i  (req_valid),
      .op_i         (op),
      .base_i       (base),
      .offset_i     (offset),
      .store_data_i (sdata),
      .mem_addr_o   (mem_addr),
      .mem_req_o    (mem_req),
      .mem_we_o     (mem_we),
      .mem_be_o     (mem_be),
      .mem_wdata_o  (mem_wdata),
      .addr_err_o   (addr_err),
      .mem_rdata_i  (rdata),
      .load_valid_o (load_valid),
      .load_data_o  (load_data)
   );

   task automatic chk(input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic drive_req(input logic [2:0] o, input logic [31:0] b,
                            input logic [15:0] off, input logic [31:0] d);
      @(negedge clk);
      req_valid = 1'b1;
      op = o;
      base = b;
      offset = off;
      sdata = d;
      #1;
   endtask

   task automatic t_reset();
      #1;
      chk("R12", "load_valid in reset", {31'd0, load_valid}, 32'd0);
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk("R12", "load_valid after reset", {31'd0, load_valid}, 32'd0);
      chk("R10", "addr_err idle", {31'd0, addr_err}, 32'd0);
   endtask

   task automatic t_addr(input logic [31:0] b, input logic [15:0] off,
                         input logic [31:0] exp);
      drive_req(3'd2, b, off, 32'd0);
      chk("R1", "effective address", mem_addr, exp);
      req_valid = 1'b0;
   endtask

   task automatic t_store(input string tag, input logic [2:0] o,
                          input logic [31:0] b, input logic [15:0] off,
                          input logic [31:0] d, input logic [3:0] exp_be,
                          input logic [31:0] exp_wd);
      drive_req(o, b, off, d);
      chk(tag, "wdata", mem_wdata, exp_wd);
      chk(tag, "byte enables", {28'd0, mem_be}, {28'd0, exp_be});
      chk("R11", "store req/we", {30'd0, mem_req, mem_we}, 32'd3);
      chk("R10", "no error on aligned store", {31'd0, addr_err}, 32'd0);
      @(negedge clk);
      req_valid = 1'b0;
      #1;
      chk("R11", "no load_valid after store", {31'd0, load_valid}, 32'd0);
   endtask

   task automatic t_load(input string tag, input logic [2:0] o,
                         input logic [31:0] b, input logic [15:0] off,
                         input logic [31:0] rd, input logic [31:0] exp);
      drive_req(o, b, off, 32'hDEAD_BEEF);
      chk("R11", "load req/we", {30'd0, mem_req, mem_we}, 32'd2);
      @(negedge clk);
      req_valid = 1'b0;
      rdata = rd;
      #1;
      chk("R11", "load_valid next cycle", {31'd0, load_valid}, 32'd1);
      chk(tag, "load data", load_data, exp);
      @(negedge clk);
      #1;
      chk("R11", "load_valid single pulse", {31'd0, load_valid}, 32'd0);
   endtask

   task automatic t_misaligned(input logic [2:0] o, input logic [31:0] b,
                               input logic [15:0] off);
      drive_req(o, b, off, 32'hFFFF_FFFF);
      chk("R10", "addr_err", {31'd0, addr_err}, 32'd1);
      chk("R10", "req/we/be gated", {27'd0, mem_req, mem_we, mem_be}, 32'd0);
      @(negedge clk);
      req_valid = 1'b0;
      #1;
      chk("R10", "no load_valid", {31'd0, load_valid}, 32'd0);
   endtask

   initial begin
      #(CLK_PERIOD * 20000);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      t_reset();
      t_addr(32'h1000_0000, 16'hFFFC, 32'h0FFF_FFFC);
      t_addr(32'h1000_0000, 16'h0010, 32'h1000_0010);
      t_addr(32'hFFFF_FFF0, 16'h0020, 32'h0000_0010);
      t_store("R2", 3'd5, 32'h100, 16'h0003, 32'hAABB_CCDD, 4'b1000, 32'hDDDD_DDDD);
      t_store("R2", 3'd5, 32'h100, 16'h0001, 32'hAABB_CC5A, 4'b0010, 32'h5A5A_5A5A);
      t_store("R3", 3'd6, 32'h200, 16'h0002, 32'h1234_5678, 4'b1100, 32'h5678_5678);
      t_store("R3", 3'd6, 32'h204, 16'hFFFC, 32'h1234_9ABC, 4'b0011, 32'h9ABC_9ABC);
      t_store("R4", 3'd7, 32'h300, 16'h0000, 32'hCAFE_F00D, 4'b1111, 32'hCAFE_F00D);
      t_load("R5", 3'd0, 32'h400, 16'h0002, 32'h1180_3344, 32'hFFFF_FF80);
      t_load("R5", 3'd0, 32'h400, 16'h0000, 32'h1180_3344, 32'h0000_0044);
      t_load("R6", 3'd3, 32'h400, 16'h0002, 32'h1180_3344, 32'h0000_0080);
      t_load("R6", 3'd3, 32'h403, 16'h0000, 32'hF000_0000, 32'h0000_00F0);
      t_load("R7", 3'd1, 32'h500, 16'h0002, 32'h8001_7FFF, 32'hFFFF_8001);
      t_load("R7", 3'd1, 32'h500, 16'h0000, 32'h8001_7FFF, 32'h0000_7FFF);
      t_load("R8", 3'd4, 32'h500, 16'h0002, 32'h8001_7FFF, 32'h0000_8001);
      t_load("R9", 3'd2, 32'h600, 16'h0004, 32'h8765_4321, 32'h8765_4321);
      t_misaligned(3'd6, 32'h200, 16'h0001);
      t_misaligned(3'd7, 32'h200, 16'h0002);
      t_misaligned(3'd2, 32'h200, 16'h0003);
      t_misaligned(3'd1, 32'h201, 16'h0000);
      t_store("R10", 3'd5, 32'h201, 16'h0002, 32'h0000_0077, 4'b1000, 32'h7777_7777);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule